// File: doc/BRIEF.md
# Interrupt Event Collector with Set/Clear Masking

This block gathers up to `NUM_SRC` single-cycle hardware event pulses into a sticky cause vector and folds it, through a per-bit enable mask, into one level-sensitive interrupt line. Software owns the block through a small synchronous register port with four locations. Every software action is either "set these bits" or "clear these bits", so no read-modify-write sequence is ever needed and two agents never race on a shared register.

Reading the cause location returns the pending causes and clears them in the same access. An event pulse that lands on the very cycle of that read is kept, so no event is lost between a read and the next one. The mask has its own set and clear locations, and the set location reads back the current mask. The register port is a plain strobe interface: a read or write strobe, a 2-bit location select and a data word. Each strobe is accepted every cycle and never stalled, so the port has no back-pressure. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `irq_cause_mask`

## Requirements
- R1: After reset the cause and mask vectors are all zero, `irq_o` is low and `reg_rdata` is zero.
- R2: A write to location 1 (cause set) sets each cause bit whose `reg_wdata` bit is 1 and leaves the bits written as 0 unchanged.
- R3: An `evt_i` bit at 1 on a clock edge sets that cause bit, whatever the mask holds.
- R4: A read of location 0 (cause read) returns the cause vector held before that edge on `reg_rdata` one cycle later, and clears every bit that was set. With no coincident event or write, the cause vector is zero on the next cycle.
- R5: If an `evt_i` bit is 1 on the same edge as a cause read, that cause bit is still set after the read.
- R6: A write to location 2 (mask set) sets each mask bit whose `reg_wdata` bit is 1 and leaves the bits written as 0 unchanged.
- R7: A write to location 3 (mask clear) clears each mask bit whose `reg_wdata` bit is 1 and leaves the bits written as 0 unchanged.
- R8: A read of location 2 returns the current mask one cycle later and changes no state. Reads of locations 1 and 3 return zero.
- R9: `irq_o` is registered. It is high exactly when, one edge earlier, some bit position had both its cause bit and its mask bit at 1.
- R10: A write to location 0 has no effect on the cause or mask vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Hardware event pulses, one per cause bit |
| reg_addr | input | 2 | Location select: 0 cause read, 1 cause set, 2 mask set/read, 3 mask clear |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | NUM_SRC | Write data, one bit per cause or mask position |
| reg_rdata | output | NUM_SRC | Read data, valid the cycle after `reg_rd`, held until the next read |
| irq_o | output | 1 | Level interrupt request |

## Verification
A cause bit stuck high or dropped shows up at the next cause read, one cycle after the strobe. A bit that is unmasked but wrong also moves `irq_o` two edges after the faulty update. A wrong mask bit stays hidden from `irq_o` until a cause arrives in that position, so the bench reads the mask back directly and also fires events into every position. A read that clears too much, losing a coincident event, only shows at the following read. For that reason every read is compared against a model on every cycle, rather than checked only at a few chosen points.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    LOC_CAUSE_RD  = 2'd0,
    LOC_CAUSE_SET = 2'd1,
    LOC_MASK_SET  = 2'd2,
    LOC_MASK_CLR  = 2'd3
  } loc_e;

  typedef struct packed {
    logic cause_rd;
    logic cause_set;
    logic mask_set;
    logic mask_clr;
    logic mask_rd;
  } strobe_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_pkg::*;
(
  input  logic [1:0] reg_addr,
  input  logic       reg_rd,
  input  logic       reg_wr,
  output strobe_t    strb
);

  loc_e loc;

  always_comb begin
    loc            = loc_e'(reg_addr);
    strb           = '0;
    strb.cause_rd  = reg_rd && (loc == LOC_CAUSE_RD);
    strb.mask_rd   = reg_rd && (loc == LOC_MASK_SET);
    strb.cause_set = reg_wr && (loc == LOC_CAUSE_SET);
    strb.mask_set  = reg_wr && (loc == LOC_MASK_SET);
    strb.mask_clr  = reg_wr && (loc == LOC_MASK_CLR);
  end

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr_all,
  input  logic               set_en,
  input  logic [NUM_SRC-1:0] set_data,
  output logic [NUM_SRC-1:0] cause_q
);

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    logic hold;
    logic raise;
    always_comb begin
      hold  = cause_q[b] && !clr_all;
      raise = evt[b] || (set_en && set_data[b]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q[b] <= 1'b0;
      else        cause_q[b] <= hold || raise;
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] data,
  output logic [NUM_SRC-1:0] mask_q
);

  logic [NUM_SRC-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (set_en) mask_d = mask_d | data;
    if (clr_en) mask_d = mask_d & ~data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_any,
  input  strobe_t            strb,
  input  logic [NUM_SRC-1:0] cause_q,
  input  logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] rdata_q
);

  logic [NUM_SRC-1:0] rsel;

  always_comb begin
    rsel = '0;
    if (strb.cause_rd) rsel = cause_q;
    if (strb.mask_rd)  rsel = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_any) rdata_q <= rsel;
  end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] cause_q,
  input  logic [NUM_SRC-1:0] mask_q,
  output logic               irq_q
);

  logic pend;

  always_comb pend = |(cause_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend;
  end

endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [1:0]         reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               irq_o
);

  strobe_t            strb;
  logic [NUM_SRC-1:0] cause_q;
  logic [NUM_SRC-1:0] mask_q;

  irq_bus_decode u_dec (
    .reg_addr (reg_addr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .strb     (strb)
  );

  irq_cause_reg #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_i),
    .clr_all  (strb.cause_rd),
    .set_en   (strb.cause_set),
    .set_data (reg_wdata),
    .cause_q  (cause_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (strb.mask_set),
    .clr_en (strb.mask_clr),
    .data   (reg_wdata),
    .mask_q (mask_q)
  );

  irq_read_port #(.NUM_SRC(NUM_SRC)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_any  (reg_rd),
    .strb    (strb),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .rdata_q (reg_rdata)
  );

  irq_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .irq_q   (irq_o)
  );

endmodule

// File: rtl/irq_cause_mask_sva.sv
module irq_cause_mask_sva #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [1:0]         reg_addr,
  input logic               reg_rd,
  input logic               reg_wr,
  input logic [NUM_SRC-1:0] reg_wdata,
  input logic [NUM_SRC-1:0] reg_rdata,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] cause_q,
  input logic [NUM_SRC-1:0] mask_q
);

  a_r2_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> ((cause_q & $past(reg_wdata)) == $past(reg_wdata)));

  a_r3_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

  a_r4_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0) |=> (reg_rdata == $past(cause_q)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && evt_i == '0 && !reg_wr) |=> (cause_q == '0));

  a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata)));

  a_r7_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> ((mask_q & $past(reg_wdata)) == '0));

  a_r8_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2) |=> (reg_rdata == $past(mask_q)));

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & mask_q) != '0) |=> irq_o);

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & mask_q) == '0) |=> !irq_o);

  a_r10_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr) |=> $stable(mask_q));

endmodule

bind irq_cause_mask irq_cause_mask_sva #(.NUM_SRC(NUM_SRC)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .reg_addr  (reg_addr),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o),
  .cause_q   (cause_q),
  .mask_q    (mask_q)
);

// File: tb/irq_cause_mask_test.sv
`timescale 1ns/1ps
module irq_cause_mask_test;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic [1:0]   reg_addr = '0;
  logic         reg_rd = 1'b0;
  logic         reg_wr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  logic [N-1:0] m_cause, m_mask, m_rd;
  logic         m_irq;

  irq_cause_mask #(.NUM_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause = '0; m_mask = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      logic [N-1:0] nc, nm;
      m_irq = (m_cause & m_mask) != '0;
      if (reg_rd) m_rd = (reg_addr == 2'd0) ? m_cause : (reg_addr == 2'd2) ? m_mask : '0;
      nc = m_cause;
      nm = m_mask;
      if (reg_rd && reg_addr == 2'd0) nc = '0;
      if (reg_wr && reg_addr == 2'd1) nc = nc | reg_wdata;
      nc = nc | evt_i;
      if (reg_wr && reg_addr == 2'd2) nm = nm | reg_wdata;
      if (reg_wr && reg_addr == 2'd3) nm = nm & ~reg_wdata;
      m_cause = nc;
      m_mask  = nm;
    end
  end

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R4, R8, R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4/R8 model rdata", reg_rdata, m_rd);
      check("R9 model irq", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, m_irq});
    end
  end

  task automatic cyc(input logic rd, input logic wr, input logic [1:0] a,
                     input logic [N-1:0] d, input logic [N-1:0] ev);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d; evt_i = ev;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = '0; evt_i = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", reg_rdata, '0);
    check("R1 irq after reset", {31'b0, irq_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: mask reads zero
    cyc(1, 0, 2'd2, '0, '0);
    check("R1 mask zero", reg_rdata, '0);
    // R3: masked event latched
    cyc(0, 0, 2'd0, '0, 32'h5);
    cyc(1, 0, 2'd0, '0, '0);
    check("R3 masked event latched", reg_rdata, 32'h5);
    check("R9 masked no irq", {31'b0, irq_o}, '0);
    // R4: cleared by previous read
    cyc(1, 0, 2'd0, '0, '0);
    check("R4 cleared on read", reg_rdata, '0);
    // R2
    cyc(0, 1, 2'd1, 32'hA0, '0);
    cyc(0, 1, 2'd1, 32'h0, '0);
    cyc(1, 0, 2'd0, '0, '0);
    check("R2 cause set", reg_rdata, 32'hA0);
    // R6 / R8
    cyc(0, 1, 2'd2, 32'h0F, '0);
    cyc(0, 1, 2'd2, 32'h00, '0);
    cyc(1, 0, 2'd2, '0, '0);
    check("R6 mask set", reg_rdata, 32'h0F);
    cyc(1, 0, 2'd2, '0, '0);
    check("R8 mask read no change", reg_rdata, 32'h0F);
    // R7
    cyc(0, 1, 2'd3, 32'h03, '0);
    cyc(0, 1, 2'd3, 32'h00, '0);
    cyc(1, 0, 2'd2, '0, '0);
    check("R7 mask clear", reg_rdata, 32'h0C);
    // R9 timing
    cyc(0, 1, 2'd1, 32'h04, '0);
    check("R9 irq not yet", {31'b0, irq_o}, '0);
    cyc(0, 0, 2'd0, '0, '0);
    check("R9 irq raised", {31'b0, irq_o}, 32'h1);
    // R5: coincident event survives read
    cyc(1, 0, 2'd0, '0, 32'h04);
    check("R5 read value", reg_rdata, 32'h04);
    cyc(1, 0, 2'd0, '0, '0);
    check("R5 event survived", reg_rdata, 32'h04);
    cyc(0, 0, 2'd0, '0, '0);
    cyc(0, 0, 2'd0, '0, '0);
    check("R9 irq dropped", {31'b0, irq_o}, '0);
    // R8 reads of write-only locations
    cyc(0, 1, 2'd1, 32'h10, '0);
    cyc(1, 0, 2'd1, '0, '0);
    check("R8 loc1 reads zero", reg_rdata, '0);
    cyc(1, 0, 2'd3, '0, '0);
    check("R8 loc3 reads zero", reg_rdata, '0);
    cyc(1, 0, 2'd0, '0, '0);
    check("R8 cause kept", reg_rdata, 32'h10);
    // R10
    cyc(0, 1, 2'd0, 32'hFFFF_FFFF, '0);
    cyc(1, 0, 2'd0, '0, '0);
    check("R10 cause untouched", reg_rdata, '0);
    cyc(1, 0, 2'd2, '0, '0);
    check("R10 mask untouched", reg_rdata, 32'h0C);
    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      logic [N-1:0] ev;
      ev = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, N-1)) : '0;
      cyc($urandom_range(0, 1), $urandom_range(0, 1), 2'($urandom_range(0, 3)),
          $urandom & $urandom, ev);
    end
    finish_run();
  end

endmodule